// File: doc/BRIEF.md
# Grouped Interrupt Controller with Per-Line Polarity

This block gathers interrupt lines from four groups of equal width: a local-bus group, an LPC group, a PCI/device group and a non-maskable group. Every line first passes through a two-flop synchronizer. It is then corrected for its configured polarity. It is sensed either as a level or as a latched edge, and finally gated by its own mask bit. Each group reports which of its lines are pending. Each group also sets one bit of a summary status word whenever it holds a pending request that is not masked.

The three ordinary groups are ORed into a single CPU interrupt output. The non-maskable group drives a separate output of its own. Software configures the block through a plain synchronous port: writes are taken on the clock edge when `wr_en` is high, and read data follows the address combinationally. The port addresses words, and the address is a word index. Index 0 is the summary status. Group g then holds four consecutive indices starting at 1+4g, in this order: request, mask, trigger, level. The groups are numbered 0 local bus, 1 LPC, 2 PCI/device and 3 non-maskable.

Top module: `grp_intc`

## Requirements
- R1: After reset, every mask register reads 0xFFFF, every trigger register reads 0x0000, every level register reads 0xFFFF, the status word reads 0, and both `cpu_irq` and `nmi_irq` are low.
- R2: Index 0 reads the status word. Index 1+4g+k reads register k of group g, where k=0 is request, 1 is mask, 2 is trigger and 3 is level. Mask, trigger and level read back the value last written to them. An index above 16 reads 0.
- R3: A mask bit of 1 keeps its line out of the status word and out of both outputs, but the line is still shown in the request register. A mask bit of 0 lets the line through.
- R4: With trigger bit 0 (level sensing), request bit n follows the active state of line n and drops once the input goes inactive.
- R5: Level bit 1 makes a line active high. Level bit 0 makes it active low.
- R6: With trigger bit 1 (edge sensing), an inactive-to-active transition of the line sets request bit n. The bit stays set after the input returns to inactive.
- R7: A write to a request register clears each latched bit whose data bit is 0 and keeps each one whose data bit is 1. Writing 0 clears every latched request of that group at once.
- R8: Status bit 0 is set by the local-bus group, bit 1 by LPC, bit 2 by PCI/device and bit 3 by the non-maskable group. A bit is set when its group has any unmasked pending request.
- R9: `cpu_irq` is the OR of status bits 0 to 2. `nmi_irq` equals status bit 3 and never raises `cpu_irq`.
- R10: A level input change that arrives between clock edges is not yet in the status word after the second following rising edge. It is in the status word after the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lb_irq_in | input | 16 | Local-bus group interrupt lines |
| lpc_irq_in | input | 16 | LPC group interrupt lines |
| dev_irq_in | input | 16 | PCI/device group interrupt lines |
| nmi_irq_in | input | 16 | Non-maskable group interrupt lines |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 5 | Register word index |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| cpu_irq | output | 1 | Combined interrupt for the three ordinary groups |
| nmi_irq | output | 1 | Non-maskable group interrupt |

## Verification
The assertions assume that every interrupt line holds each value for at least one full clock period. They also assume that a request write is meant as a clear mask, so a 1 in the write data never sets a request. The directed tests therefore change inputs only on falling edges and hold them for two or more cycles. They raise requests only through the input lines. Before any further check, they wait at least three edges after a change so that it can cross the synchronizer and the status register.

// File: rtl/grp_intc_pkg.sv
package grp_intc_pkg;
    // group ordering is fixed: it defines the status bit positions
    localparam int NGRP      = 4;
    localparam int G_LB      = 0;
    localparam int G_LPC     = 1;
    localparam int G_DEV     = 2;
    localparam int G_NMI     = 3;
    localparam int REGS_PER  = 4;
    localparam int FIRST_GRP = 1;

    typedef enum logic [1:0] {
        K_REQ  = 2'd0,
        K_MASK = 2'd1,
        K_TRIG = 2'd2,
        K_LVL  = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/grp_intc_sync.sv
module grp_intc_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/grp_intc_group.sv
module grp_intc_group #(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_i,
    input  logic             wr_req_i,
    input  logic             wr_mask_i,
    input  logic             wr_trig_i,
    input  logic             wr_lvl_i,
    input  logic [LINES-1:0] wdata_i,
    output logic [LINES-1:0] mask_o,
    output logic [LINES-1:0] trig_o,
    output logic [LINES-1:0] lvl_o,
    output logic [LINES-1:0] pend_o,
    output logic             hit_o
);
    typedef struct packed {
        logic [LINES-1:0] mask;
        logic [LINES-1:0] trig;
        logic [LINES-1:0] lvl;
        logic [LINES-1:0] latch;
        logic [LINES-1:0] act_prev;
    } grp_st_t;

    grp_st_t st_d, st_q;

    logic [LINES-1:0] sync_line;
    logic [LINES-1:0] act;
    logic [LINES-1:0] rise;
    logic [LINES-1:0] clr;

    grp_intc_sync #(.W(LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (line_i),
        .sync_o (sync_line)
    );

    always_comb begin
        act  = ~(sync_line ^ st_q.lvl);
        rise = act & ~st_q.act_prev;
        clr  = wr_req_i ? ~wdata_i : '0;

        st_d          = st_q;
        st_d.act_prev = act;
        st_d.latch    = st_q.trig & ((st_q.latch & ~clr) | rise);
        if (wr_mask_i) st_d.mask = wdata_i;
        if (wr_trig_i) st_d.trig = wdata_i;
        if (wr_lvl_i)  st_d.lvl  = wdata_i;

        pend_o = (st_q.trig & st_q.latch) | (~st_q.trig & act);
        hit_o  = |(pend_o & ~st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask     <= '1;
            st_q.trig     <= '0;
            st_q.lvl      <= '1;
            st_q.latch    <= '0;
            st_q.act_prev <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;
    assign trig_o = st_q.trig;
    assign lvl_o  = st_q.lvl;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_q.mask == '1 && st_q.trig == '0 && st_q.latch == '0));

    // R6
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.latch & st_q.trig & ~clr) & ~st_q.latch) == '0));

    // R7
    req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_i |=> ((st_q.latch & ~$past(wdata_i) & ~$past(rise)) == '0));
endmodule

// File: rtl/grp_intc_rdmux.sv
module grp_intc_rdmux
    import grp_intc_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [NGRP-1:0]             status_i,
    input  logic [NGRP-1:0][LINES-1:0]  pend_i,
    input  logic [NGRP-1:0][LINES-1:0]  mask_i,
    input  logic [NGRP-1:0][LINES-1:0]  trig_i,
    input  logic [NGRP-1:0][LINES-1:0]  lvl_i,
    output logic [LINES-1:0]            rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (addr_i == '0) begin
            rdata_o[NGRP-1:0] = status_i;
        end
        for (int g = 0; g < NGRP; g++) begin
            if (addr_i == ADDR_W'(FIRST_GRP + g*REGS_PER + int'(K_REQ)))  rdata_o = pend_i[g];
            if (addr_i == ADDR_W'(FIRST_GRP + g*REGS_PER + int'(K_MASK))) rdata_o = mask_i[g];
            if (addr_i == ADDR_W'(FIRST_GRP + g*REGS_PER + int'(K_TRIG))) rdata_o = trig_i[g];
            if (addr_i == ADDR_W'(FIRST_GRP + g*REGS_PER + int'(K_LVL)))  rdata_o = lvl_i[g];
        end
    end
endmodule

// File: rtl/grp_intc.sv
module grp_intc
    import grp_intc_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  lb_irq_in,
    input  logic [LINES-1:0]  lpc_irq_in,
    input  logic [LINES-1:0]  dev_irq_in,
    input  logic [LINES-1:0]  nmi_irq_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LINES-1:0]  wdata,
    output logic [LINES-1:0]  rdata,
    output logic              cpu_irq,
    output logic              nmi_irq
);
    typedef struct packed {
        logic [NGRP-1:0] status;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NGRP-1:0][LINES-1:0] lines_w;
    logic [NGRP-1:0][LINES-1:0] pend_w, mask_w, trig_w, lvl_w;
    logic [NGRP-1:0]            hit_w;
    logic [NGRP-1:0]            wr_req_w, wr_mask_w, wr_trig_w, wr_lvl_w;

    assign lines_w[G_LB]  = lb_irq_in;
    assign lines_w[G_LPC] = lpc_irq_in;
    assign lines_w[G_DEV] = dev_irq_in;
    assign lines_w[G_NMI] = nmi_irq_in;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int BASE = FIRST_GRP + g*REGS_PER;

        assign wr_req_w[g]  = wr_en && (addr == ADDR_W'(BASE + int'(K_REQ)));
        assign wr_mask_w[g] = wr_en && (addr == ADDR_W'(BASE + int'(K_MASK)));
        assign wr_trig_w[g] = wr_en && (addr == ADDR_W'(BASE + int'(K_TRIG)));
        assign wr_lvl_w[g]  = wr_en && (addr == ADDR_W'(BASE + int'(K_LVL)));

        grp_intc_group #(.LINES(LINES)) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_i    (lines_w[g]),
            .wr_req_i  (wr_req_w[g]),
            .wr_mask_i (wr_mask_w[g]),
            .wr_trig_i (wr_trig_w[g]),
            .wr_lvl_i  (wr_lvl_w[g]),
            .wdata_i   (wdata),
            .mask_o    (mask_w[g]),
            .trig_o    (trig_w[g]),
            .lvl_o     (lvl_w[g]),
            .pend_o    (pend_w[g]),
            .hit_o     (hit_w[g])
        );

        // R3
        masked_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (&mask_w[g]) |=> !st_q.status[g]);
    end

    always_comb begin
        st_d        = st_q;
        st_d.status = hit_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_irq = st_q.status[G_LB] | st_q.status[G_LPC] | st_q.status[G_DEV];
    assign nmi_irq = st_q.status[G_NMI];

    grp_intc_rdmux #(.LINES(LINES), .ADDR_W(ADDR_W)) u_rd (
        .addr_i   (addr),
        .status_i (st_q.status),
        .pend_i   (pend_w),
        .mask_i   (mask_w),
        .trig_i   (trig_w),
        .lvl_i    (lvl_w),
        .rdata_o  (rdata)
    );

    // R9
    nmi_separate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_irq_in == '0 && lpc_irq_in == '0 && dev_irq_in == '0 &&
         $past(lb_irq_in == '0 && lpc_irq_in == '0 && dev_irq_in == '0) &&
         $past(hit_w[G_LB] | hit_w[G_LPC] | hit_w[G_DEV]) == 1'b0 &&
         (hit_w[G_LB] | hit_w[G_LPC] | hit_w[G_DEV]) == 1'b0) |=> !cpu_irq);
endmodule

// File: tb/sim_grp_intc.sv
`timescale 1ns/1ps
module sim_grp_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] lb_in = '0, lpc_in = '0, dev_in = '0, nmi_in = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        cpu_irq, nmi_irq;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    grp_intc u0 (
        .clk(clk), .rst_n(rst_n),
        .lb_irq_in(lb_in), .lpc_irq_in(lpc_in), .dev_irq_in(dev_in), .nmi_irq_in(nmi_in),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .cpu_irq(cpu_irq), .nmi_irq(nmi_irq)
    );

    function automatic logic [4:0] ra(int g, int k);
        return 5'(1 + 4*g + k);
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        lb_in = '0; lpc_in = '0; dev_in = '0; nmi_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0;
    endtask

    task automatic rd(logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
        addr = '0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        for (int g = 0; g < 4; g++) begin
            rd(ra(g, 1), d); chk("R1 mask reset", d, 16'hFFFF);
            rd(ra(g, 2), d); chk("R1 trig reset", d, 16'h0000);
            rd(ra(g, 3), d); chk("R1 level reset", d, 16'hFFFF);
        end
        rd(5'd0, d); chk("R1 status reset", d, 16'h0000);
        chk("R1 outputs reset", {14'd0, cpu_irq, nmi_irq}, 16'h0);
    endtask

    task automatic t_regmap();
        logic [15:0] d;
        do_reset();
        wr(ra(0, 1), 16'h1234);
        wr(ra(2, 2), 16'h00F0);
        wr(ra(3, 3), 16'h5555);
        wr(ra(1, 1), 16'hA5A5);
        rd(ra(0, 1), d); chk("R2 lb mask", d, 16'h1234);
        rd(ra(2, 2), d); chk("R2 dev trig", d, 16'h00F0);
        rd(ra(3, 3), d); chk("R2 nmi level", d, 16'h5555);
        rd(ra(1, 1), d); chk("R2 lpc mask", d, 16'hA5A5);
        rd(ra(2, 1), d); chk("R2 dev mask untouched", d, 16'hFFFF);
        rd(5'd20, d);    chk("R2 unmapped", d, 16'h0000);
    endtask

    task automatic t_level_latency();
        logic [15:0] d;
        do_reset();
        wr(ra(0, 1), 16'hFFF7);
        @(negedge clk); addr = 5'd0; lb_in = 16'h0008;
        @(posedge clk); @(posedge clk); #1;
        chk("R10 status not yet after two edges", rdata, 16'h0000);
        @(posedge clk); #1;
        chk("R10 status after third edge", rdata, 16'h0001);
        chk("R8 R9 cpu_irq from lb", {15'd0, cpu_irq}, 16'h1);
        rd(ra(0, 0), d); chk("R4 lb request", d, 16'h0008);
        @(negedge clk); lb_in = '0;
        repeat (4) @(negedge clk);
        rd(ra(0, 0), d); chk("R4 level drops", d, 16'h0000);
        rd(5'd0, d); chk("R4 status drops", d, 16'h0000);
    endtask

    task automatic t_polarity();
        logic [15:0] d;
        do_reset();
        wr(ra(2, 3), 16'hFFDF);
        wr(ra(2, 1), 16'hFFDF);
        repeat (4) @(negedge clk);
        rd(ra(2, 0), d); chk("R5 active-low pending when low", d, 16'h0020);
        rd(5'd0, d); chk("R5 R8 dev status bit", d, 16'h0004);
        @(negedge clk); dev_in = 16'h0020;
        repeat (4) @(negedge clk);
        rd(ra(2, 0), d); chk("R5 active-low idle when high", d, 16'h0000);
        chk("R5 cpu_irq low", {15'd0, cpu_irq}, 16'h0);
    endtask

    task automatic t_mask();
        logic [15:0] d;
        do_reset();
        @(negedge clk); lpc_in = 16'h0001;
        repeat (4) @(negedge clk);
        rd(ra(1, 0), d); chk("R3 masked line still visible", d, 16'h0001);
        rd(5'd0, d); chk("R3 masked keeps status clear", d, 16'h0000);
        chk("R3 masked keeps cpu_irq low", {15'd0, cpu_irq}, 16'h0);
        wr(ra(1, 1), 16'hFFFE);
        repeat (2) @(negedge clk);
        rd(5'd0, d); chk("R3 R8 unmasked sets lpc bit", d, 16'h0002);
    endtask

    task automatic t_edge_clear();
        logic [15:0] d;
        do_reset();
        wr(ra(1, 2), 16'h0003);
        wr(ra(1, 1), 16'hFFFC);
        @(negedge clk); lpc_in = 16'h0003;
        repeat (2) @(negedge clk);
        lpc_in = '0;
        repeat (5) @(negedge clk);
        rd(ra(1, 0), d); chk("R6 edge latched after input drops", d, 16'h0003);
        rd(5'd0, d); chk("R6 edge holds status", d, 16'h0002);
        wr(ra(1, 0), 16'h0001);
        rd(ra(1, 0), d); chk("R7 partial clear keeps bit0", d, 16'h0001);
        wr(ra(1, 0), 16'h0000);
        rd(ra(1, 0), d); chk("R7 write zero clears all", d, 16'h0000);
        @(negedge clk);
        rd(5'd0, d); chk("R7 status clear after clear", d, 16'h0000);
    endtask

    task automatic t_nmi();
        logic [15:0] d;
        do_reset();
        wr(ra(3, 1), 16'hFF7F);
        @(negedge clk); nmi_in = 16'h0080;
        repeat (4) @(negedge clk);
        rd(5'd0, d); chk("R8 nmi status bit3", d, 16'h0008);
        chk("R9 nmi output high", {15'd0, nmi_irq}, 16'h1);
        chk("R9 nmi leaves cpu_irq low", {15'd0, cpu_irq}, 16'h0);
        wr(ra(2, 1), 16'hFFFE);
        @(negedge clk); dev_in = 16'h0001;
        repeat (4) @(negedge clk);
        rd(5'd0, d); chk("R8 dev and nmi bits", d, 16'h000C);
        chk("R9 cpu_irq from dev", {15'd0, cpu_irq}, 16'h1);
    endtask

    initial begin
        t_reset();
        t_regmap();
        t_level_latency();
        t_polarity();
        t_mask();
        t_edge_clear();
        t_nmi();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule